// File: doc/BRIEF.md
# Multichannel DMA Controller with Bus Tenure Limit

The block is a small DMA engine with a parameterized number of channels. Each channel serves one peripheral through a request/acknowledge pair. Each channel holds its own source address, destination address, word count and control register. When one or more channels are pending, a fixed-priority picker chooses one. The controller then asks the shared system bus for ownership with `bus_req` and waits for `bus_grant`. After the grant it copies words. Each word is a read cycle on `mem_addr` followed by a write cycle one clock later, and the write data is the read data that memory returns.

A channel works either in single mode or in block mode. In single mode it moves one word per peripheral request. In block mode one request moves the whole count. A block is cut into bus tenures of at most a programmable number of words. After each tenure the bus is released and the controller arbitrates again, so a lower-index channel can step in between two tenures of a long block. When `bus_grant` is low the CPU reaches the registers through a plain synchronous write and combinational read port. When `bus_grant` is high that port is shut.

Top module: `mcdma_ctrl`

## Requirements
- R1: Among pending channels, the lowest index is served first. A channel is pending when it is enabled, its count is non-zero, and either its request is high or it has an unfinished block.
- R2: `bus_req` rises when a channel is picked. It stays high until the last word of the tenure is written. `mem_rd`/`mem_wr` are never active unless `bus_grant` is high.
- R3: Each word is one `mem_rd` cycle at the source address, followed in the next cycle by one `mem_wr` cycle at the destination address carrying `mem_rdata`. The served channel's `periph_ack` bit is high only in that write cycle, and at most one ack bit is high at any time.
- R4: A channel in single mode moves exactly one word per request and then releases the bus.
- R5: A channel in block mode moves its entire count after a single request, with no further requests, over as many tenures as needed.
- R6: A tenure ends after N words, where N is the burst-limit register (values 0 and 1 both mean one word), or earlier at count end or in single mode. The bus is then released and requested again. A channel that yields mid-block is arbitrated again against the other pending channels.
- R7: The count decrements by one per word. Source and destination addresses each increment by one per word, unless that channel's fixed-source or fixed-destination bit is set.
- R8: When the count reaches zero, the channel's done flag is set and its enable is cleared. `irq` is high for exactly one cycle, the cycle after the final write.
- R9: While `bus_grant` is high, register writes are ignored and `reg_rdata` reads zero.
- R10: A channel whose enable bit is 0 ignores its request line. Writing the control register with bit 4 set clears the done flag.
- R11: Register map. Address `4*c+0` is the source, `4*c+1` the destination, `4*c+2` the count and `4*c+3` the control of channel c. Control bits are: 0 enable, 1 block mode, 2 fixed source, 3 fixed destination, 4 done (reads the flag; writing 1 clears it). Address `4*NCH` is the burst limit (LW bits, reset value 4). Every other address reads 0. All channel registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| periph_req | input | NCH | Per-channel peripheral request |
| periph_ack | output | NCH | Per-channel acknowledge pulse |
| bus_req | output | 1 | System bus ownership request |
| bus_grant | input | 1 | System bus grant |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | RAW | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data |
| mem_addr | output | AW | Memory bus address |
| mem_rd | output | 1 | Memory read strobe (data returns next cycle) |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| irq | output | 1 | Completion pulse |

## Verification
The interesting collision is a channel's final word landing exactly on the burst-limit boundary. In that write cycle the count-end path and the tenure-limit path both ask for a release. The bench provokes it by programming a count equal to the limit. It then judges the outcome at the ports: exactly one `bus_req` rising edge, exactly one single-cycle `irq`, the done flag set, the enable cleared, and no further bus request for that channel. The same path is also reached through the yield test. There a waiting single-mode request on a lower channel must win the arbitration that sits between two tenures of a block.

// File: rtl/mcdma_pkg.sv
package mcdma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_RD,
        ST_WR,
        ST_REL
    } dma_st_e;

    // control register bit positions
    localparam int CTL_EN   = 0;
    localparam int CTL_BLK  = 1;
    localparam int CTL_FXS  = 2;
    localparam int CTL_FXD  = 3;
    localparam int CTL_DONE = 4;
    localparam int CTL_W    = 5;

    // register offsets inside a channel slot
    localparam logic [1:0] SEL_SRC = 2'd0;
    localparam logic [1:0] SEL_DST = 2'd1;
    localparam logic [1:0] SEL_CNT = 2'd2;
    localparam logic [1:0] SEL_CTL = 2'd3;

endpackage

// File: rtl/mcdma_prio_pick.sv
module mcdma_prio_pick #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  pend,
    output logic [IW-1:0] idx,
    output logic          any
);

    // lowest index wins: scan downward so the last hit is the smallest
    always_comb begin
        idx = '0;
        any = |pend;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) begin
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/mcdma_chan.sv
module mcdma_chan
    import mcdma_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DW-1:0]     wdata,
    input  logic              req,
    input  logic              start,
    input  logic              step,
    output logic [AW-1:0]     src,
    output logic [AW-1:0]     dst,
    output logic [CW-1:0]     cnt,
    output logic [CTL_W-1:0]  ctl,
    output logic              pending,
    output logic              last
);

    typedef struct packed {
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [CW-1:0] cnt;
        logic          en;
        logic          blk;
        logic          fxs;
        logic          fxd;
        logic          done;
        logic          act;    // block in progress, survives bus yields
    } chan_t;

    chan_t q, d;

    always_comb begin
        d = q;
        if (wr_en) begin
            case (wr_sel)
                SEL_SRC: d.src = AW'(wdata);
                SEL_DST: d.dst = AW'(wdata);
                SEL_CNT: d.cnt = CW'(wdata);
                SEL_CTL: begin
                    d.en  = wdata[CTL_EN];
                    d.blk = wdata[CTL_BLK];
                    d.fxs = wdata[CTL_FXS];
                    d.fxd = wdata[CTL_FXD];
                    d.act = 1'b0;
                    if (wdata[CTL_DONE]) begin
                        d.done = 1'b0;
                    end
                end
                default: ;
            endcase
        end
        if (start) begin
            d.act = q.blk;
        end
        if (step && (q.cnt != '0)) begin
            if (!q.fxs) d.src = q.src + 1'b1;
            if (!q.fxd) d.dst = q.dst + 1'b1;
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CW'(1)) begin
                d.done = 1'b1;
                d.en   = 1'b0;
                d.act  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign src     = q.src;
    assign dst     = q.dst;
    assign cnt     = q.cnt;
    assign ctl     = {q.done, q.fxd, q.fxs, q.blk, q.en};
    assign pending = q.en && (q.cnt != '0) && (req || q.act);
    assign last    = (q.cnt == CW'(1));

endmodule

// File: rtl/mcdma_ctrl.sv
module mcdma_ctrl
    import mcdma_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int DW  = 16,
    parameter int CW  = 16,
    parameter int LW  = 4,
    localparam int IW  = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int LIM_ADDR = NCH * 4,
    localparam int RAW = $clog2(LIM_ADDR + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  periph_req,
    output logic [NCH-1:0]  periph_ack,
    output logic            bus_req,
    input  logic            bus_grant,
    input  logic            reg_wr,
    input  logic [RAW-1:0]  reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    output logic            irq
);

    typedef struct packed {
        dma_st_e       st;
        logic [IW-1:0] cur;
        logic [LW-1:0] bcnt;
        logic [LW-1:0] lim;
        logic          irq;
    } ctrl_t;

    ctrl_t q, d;

    logic [AW-1:0]    ch_src [NCH];
    logic [AW-1:0]    ch_dst [NCH];
    logic [CW-1:0]    ch_cnt [NCH];
    logic [CTL_W-1:0] ch_ctl [NCH];
    logic [NCH-1:0]   ch_pend;
    logic [NCH-1:0]   ch_last;
    logic [NCH-1:0]   ch_start;
    logic [NCH-1:0]   ch_step;
    logic [IW-1:0]    pick;
    logic             any_pend;

    logic             cpu_ok;
    logic             in_chan_space;
    logic [IW-1:0]    rch;

    assign cpu_ok        = !bus_grant;
    assign in_chan_space = (reg_addr < RAW'(LIM_ADDR));
    assign rch           = reg_addr[IW+1:2];

    mcdma_prio_pick #(.N(NCH)) u_pick (
        .pend (ch_pend),
        .idx  (pick),
        .any  (any_pend)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic sel_wr;
        assign sel_wr      = reg_wr && cpu_ok && in_chan_space && (rch == IW'(i));
        assign ch_start[i] = (q.st == ST_IDLE) && any_pend && (pick == IW'(i));
        assign ch_step[i]  = (q.st == ST_WR) && (q.cur == IW'(i));

        mcdma_chan #(.AW(AW), .CW(CW), .DW(DW)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (sel_wr),
            .wr_sel  (reg_addr[1:0]),
            .wdata   (reg_wdata),
            .req     (periph_req[i]),
            .start   (ch_start[i]),
            .step    (ch_step[i]),
            .src     (ch_src[i]),
            .dst     (ch_dst[i]),
            .cnt     (ch_cnt[i]),
            .ctl     (ch_ctl[i]),
            .pending (ch_pend[i]),
            .last    (ch_last[i])
        );
    end

    logic          cur_last;
    logic          cur_blk;
    logic [LW:0]   words_n;
    logic          lim_hit;

    assign cur_last = ch_last[q.cur];
    assign cur_blk  = ch_ctl[q.cur][CTL_BLK];
    assign words_n  = {1'b0, q.bcnt} + 1'b1;
    assign lim_hit  = (words_n >= {1'b0, q.lim});

    always_comb begin
        d     = q;
        d.irq = 1'b0;
        if (reg_wr && cpu_ok && (reg_addr == RAW'(LIM_ADDR))) begin
            d.lim = reg_wdata[LW-1:0];
        end
        case (q.st)
            ST_IDLE: begin
                if (any_pend) begin
                    d.cur  = pick;
                    d.bcnt = '0;
                    d.st   = ST_REQ;
                end
            end
            ST_REQ: begin
                if (bus_grant) d.st = ST_RD;
            end
            ST_RD: d.st = ST_WR;
            ST_WR: begin
                d.irq = cur_last;
                if (cur_last || !cur_blk || lim_hit) begin
                    d.st   = ST_REL;
                    d.bcnt = '0;
                end else begin
                    d.st   = ST_RD;
                    d.bcnt = q.bcnt + 1'b1;
                end
            end
            ST_REL: begin
                if (!bus_grant) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.lim  <= LW'(4);
        end else begin
            q <= d;
        end
    end

    assign bus_req    = (q.st == ST_REQ) || (q.st == ST_RD) || (q.st == ST_WR);
    assign mem_rd     = (q.st == ST_RD);
    assign mem_wr     = (q.st == ST_WR);
    assign mem_addr   = (q.st == ST_WR) ? ch_dst[q.cur] : ch_src[q.cur];
    assign mem_wdata  = mem_rdata;
    assign periph_ack = ch_step;
    assign irq        = q.irq;

    always_comb begin
        reg_rdata = '0;
        if (cpu_ok) begin
            if (reg_addr == RAW'(LIM_ADDR)) begin
                reg_rdata = DW'(q.lim);
            end else if (in_chan_space) begin
                case (reg_addr[1:0])
                    SEL_SRC: reg_rdata = DW'(ch_src[rch]);
                    SEL_DST: reg_rdata = DW'(ch_dst[rch]);
                    SEL_CNT: reg_rdata = DW'(ch_cnt[rch]);
                    default: reg_rdata = DW'(ch_ctl[rch]);
                endcase
            end
        end
    end

endmodule

// File: rtl/mcdma_ctrl_chk.sv
module mcdma_ctrl_chk #(
    parameter int NCH = 4,
    parameter int DW  = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] periph_ack,
    input logic           bus_req,
    input logic           bus_grant,
    input logic           mem_rd,
    input logic           mem_wr,
    input logic           irq,
    input logic [DW-1:0]  reg_rdata
);

    assert_ack_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(periph_ack));

    assert_ack_in_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|periph_ack) |-> mem_wr);

    assert_read_then_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> mem_wr);

    assert_no_cycle_wo_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> (bus_grant && bus_req));

    assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !mem_wr) |=> bus_req);

    assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_irq_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(mem_wr));

    assert_regs_hidden_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_grant |-> (reg_rdata == '0));

endmodule

bind mcdma_ctrl mcdma_ctrl_chk #(.NCH(NCH), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .periph_ack (periph_ack),
    .bus_req    (bus_req),
    .bus_grant  (bus_grant),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .irq        (irq),
    .reg_rdata  (reg_rdata)
);

// File: tb/mcdma_ctrl_tb.sv
module mcdma_ctrl_tb;

    localparam int NCH = 4;
    localparam int AW  = 16;
    localparam int DW  = 16;
    localparam int RAW = $clog2(NCH * 4 + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NCH-1:0]  preq;
    logic [NCH-1:0]  raise = '0;
    logic [NCH-1:0]  drop = '0;
    logic [NCH-1:0]  periph_ack;
    logic            bus_req;
    logic            grant;
    logic            allow = 1'b1;
    logic            hold = 1'b0;
    logic            reg_wr = 1'b0;
    logic [RAW-1:0]  reg_addr = '0;
    logic [DW-1:0]   reg_wdata = '0;
    logic [DW-1:0]   reg_rdata;
    logic [AW-1:0]   mem_addr;
    logic            mem_rd;
    logic            mem_wr;
    logic [DW-1:0]   mem_wdata;
    logic [DW-1:0]   mem_rdata;
    logic            irq;

    logic [15:0] mem [256];
    int checks = 0;
    int failures = 0;
    int ack_cnt [NCH];
    int irq_cnt = 0;
    int irq_late = 0;
    int rises = 0;
    int memact = 0;
    int log_n = 0;
    int ack_log [64];
    logic prev_breq = 1'b0;
    logic prev_wr = 1'b0;

    always #2 clk = ~clk;

    mcdma_ctrl #(.NCH(NCH), .AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .periph_req(preq), .periph_ack(periph_ack),
        .bus_req(bus_req), .bus_grant(grant), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .irq(irq)
    );

    // memory, bus arbiter and peripheral models
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 16'hA000 + 16'(i);
            mem_rdata <= '0;
            grant     <= 1'b0;
            preq      <= '0;
        end else begin
            if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
            if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
            grant <= (bus_req && allow) || hold;
            preq  <= (preq | raise) & ~periph_ack & ~drop;
        end
    end

    // observation counters
    always @(posedge clk) begin
        prev_breq <= bus_req;
        prev_wr   <= mem_wr;
        if (rst_n) begin
            if (bus_req && !prev_breq) rises <= rises + 1;
            if (irq) irq_cnt <= irq_cnt + 1;
            if (irq && !prev_wr) irq_late <= irq_late + 1;
            if (mem_rd || mem_wr) memact <= memact + 1;
            for (int i = 0; i < NCH; i++) begin
                if (periph_ack[i]) begin
                    ack_cnt[i] <= ack_cnt[i] + 1;
                    ack_log[log_n % 64] <= i;
                    log_n <= log_n + 1;
                end
            end
        end
    end

    // {addr, write data, expected readback}
    localparam logic [36:0] VEC [7] = '{
        {5'd0,  16'h1234, 16'h1234},
        {5'd5,  16'hBEEF, 16'hBEEF},
        {5'd10, 16'h0007, 16'h0007},
        {5'd15, 16'h001E, 16'h000E},
        {5'd16, 16'h00F3, 16'h0003},
        {5'd3,  16'h0006, 16'h0006},
        {5'd17, 16'hFFFF, 16'h0000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < NCH; i++) ack_cnt[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [RAW-1:0] a, input logic [DW-1:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [RAW-1:0] a, output logic [DW-1:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic raise_mask(input logic [NCH-1:0] m);
        @(negedge clk);
        raise = m;
        @(negedge clk);
        raise = '0;
    endtask

    task automatic wait_quiet();
        int quiet = 0;
        int t = 0;
        while (quiet < 6 && t < 3000) begin
            @(negedge clk);
            t++;
            if (!bus_req && !grant && preq == '0) quiet++;
            else quiet = 0;
        end
    endtask

    task automatic setup_ch(input int c, input logic [15:0] s, input logic [15:0] dd,
                            input logic [15:0] n, input logic [15:0] ctl);
        reg_write(RAW'(c * 4 + 0), s);
        reg_write(RAW'(c * 4 + 1), dd);
        reg_write(RAW'(c * 4 + 2), n);
        reg_write(RAW'(c * 4 + 3), ctl);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [DW-1:0] rd;
        int r0, i0, a0, m0, lb;

        do_reset();

        // table walk: register write/readback (R11)
        for (int k = 0; k < 7; k++) begin
            reg_write(VEC[k][36:32], VEC[k][31:16]);
            reg_read(VEC[k][36:32], rd);
            chk("R11 regmap vector", 32'(rd), 32'(VEC[k][15:0]));
        end

        // reset state
        do_reset();
        chk("R2 reset bus_req", 32'(bus_req), 0);
        chk("R8 reset irq", 32'(irq), 0);
        chk("R3 reset ack", 32'(periph_ack), 0);
        reg_read(5'd16, rd); chk("R11 reset limit", 32'(rd), 4);
        reg_read(5'd0, rd);  chk("R11 reset src", 32'(rd), 0);

        // single mode, two requests
        setup_ch(1, 16'd16, 16'd64, 16'd2, 16'h0001);
        i0 = irq_cnt;
        raise_mask(4'b0010); wait_quiet();
        chk("R4 single word moved", 32'(mem[64]), 32'h0000A010);
        chk("R4 second word untouched", 32'(mem[65]), 32'h0000A041);
        reg_read(5'd6, rd); chk("R7 count decremented", 32'(rd), 1);
        reg_read(5'd4, rd); chk("R7 src incremented", 32'(rd), 17);
        reg_read(5'd5, rd); chk("R7 dst incremented", 32'(rd), 65);
        chk("R3 one ack", 32'(ack_cnt[1]), 1);
        raise_mask(4'b0010); wait_quiet();
        chk("R4 second request word", 32'(mem[65]), 32'h0000A011);
        reg_read(5'd7, rd); chk("R8 done set enable cleared", 32'(rd), 32'h10);
        chk("R8 one irq", 32'(irq_cnt - i0), 1);
        reg_write(5'd7, 16'h0010);
        reg_read(5'd7, rd); chk("R10 done cleared by write", 32'(rd), 0);

        // block mode with burst limit 2, count 5 -> three tenures
        reg_write(5'd16, 16'd2);
        setup_ch(0, 16'd32, 16'd96, 16'd5, 16'h0003);
        r0 = rises; i0 = irq_cnt;
        raise_mask(4'b0001); wait_quiet();
        chk("R6 three tenures", 32'(rises - r0), 3);
        for (int k = 0; k < 5; k++) chk("R5 block data", 32'(mem[96 + k]), 32'hA020 + 32'(k));
        chk("R5 five acks", 32'(ack_cnt[0]), 5);
        reg_read(5'd3, rd); chk("R8 block done", 32'(rd), 32'h12);
        chk("R8 block irq", 32'(irq_cnt - i0), 1);

        // priority: channels 2 and 3 together
        setup_ch(2, 16'd40, 16'd110, 16'd1, 16'h0003);
        setup_ch(3, 16'd41, 16'd111, 16'd1, 16'h0003);
        lb = log_n;
        raise_mask(4'b1100); wait_quiet();
        chk("R1 lower channel first", 32'(ack_log[lb % 64]), 2);
        chk("R1 higher channel second", 32'(ack_log[(lb + 1) % 64]), 3);

        // yield: channel 0 steps in between tenures of channel 3
        setup_ch(3, 16'd48, 16'd120, 16'd4, 16'h0013);
        setup_ch(0, 16'd50, 16'd130, 16'd1, 16'h0011);
        lb = log_n;
        raise_mask(4'b1000);
        while (!bus_req) @(negedge clk);
        raise_mask(4'b0001); wait_quiet();
        chk("R6 yield order 0", 32'(ack_log[lb % 64]), 3);
        chk("R6 yield order 1", 32'(ack_log[(lb + 1) % 64]), 3);
        chk("R1 yield order 2", 32'(ack_log[(lb + 2) % 64]), 0);
        chk("R6 yield order 3", 32'(ack_log[(lb + 3) % 64]), 3);
        chk("R5 yield block tail", 32'(mem[123]), 32'h0000A033);

        // fixed source address
        reg_write(5'd16, 16'd4);
        setup_ch(1, 16'd20, 16'd140, 16'd3, 16'h0017);
        raise_mask(4'b0010); wait_quiet();
        for (int k = 0; k < 3; k++) chk("R7 fixed src data", 32'(mem[140 + k]), 32'h0000A014);
        reg_read(5'd4, rd); chk("R7 fixed src held", 32'(rd), 20);
        reg_read(5'd5, rd); chk("R7 dst advanced", 32'(rd), 143);

        // register port gated by grant
        reg_write(5'd10, 16'd9);
        hold = 1'b1;
        repeat (2) @(negedge clk);
        reg_read(5'd10, rd); chk("R9 read hidden under grant", 32'(rd), 0);
        reg_write(5'd10, 16'd5);
        hold = 1'b0;
        repeat (3) @(negedge clk);
        reg_read(5'd10, rd); chk("R9 write ignored under grant", 32'(rd), 9);

        // disabled channel ignores its request
        reg_write(5'd11, 16'h0010);
        r0 = rises; a0 = ack_cnt[2];
        raise_mask(4'b0100);
        repeat (20) @(negedge clk);
        chk("R10 disabled no bus request", 32'(rises - r0), 0);
        chk("R10 disabled no ack", 32'(ack_cnt[2] - a0), 0);
        drop = 4'b0100; @(negedge clk); drop = '0;

        // no bus cycle before grant
        allow = 1'b0;
        setup_ch(0, 16'd60, 16'd150, 16'd1, 16'h0011);
        m0 = memact;
        raise_mask(4'b0001);
        repeat (10) @(negedge clk);
        chk("R2 request held without grant", 32'(bus_req), 1);
        chk("R2 no bus cycle without grant", 32'(memact - m0), 0);
        allow = 1'b1;
        wait_quiet();
        chk("R2 word after grant", 32'(mem[150]), 32'h0000A03C);

        // count end coincides with burst limit
        reg_write(5'd16, 16'd2);
        setup_ch(1, 16'd70, 16'd160, 16'd2, 16'h0013);
        r0 = rises; i0 = irq_cnt;
        raise_mask(4'b0010); wait_quiet();
        repeat (10) @(negedge clk);
        chk("R6 single tenure at coincidence", 32'(rises - r0), 1);
        chk("R8 single irq at coincidence", 32'(irq_cnt - i0), 1);
        reg_read(5'd7, rd); chk("R8 done at coincidence", 32'(rd), 32'h12);
        chk("R3 last word at coincidence", 32'(mem[161]), 32'h0000A047);

        // burst limit 0 behaves as one word per tenure
        reg_write(5'd16, 16'd0);
        setup_ch(2, 16'd80, 16'd170, 16'd3, 16'h0013);
        r0 = rises;
        raise_mask(4'b0100); wait_quiet();
        chk("R6 limit zero one word per tenure", 32'(rises - r0), 3);

        chk("R8 irq always follows a write", 32'(irq_late), 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule